// File: doc/BRIEF.md
# Select-Synchronized Serial Slave Shift Engine

This block is the receive and transmit core of a serial peripheral slave port. An external master supplies the serial clock, the slave-select line and the serial data input. The block shifts one byte per frame, most significant bit first. It returns the byte held in its transmit buffer on the serial output and places the byte it collects into a receive buffer. All three serial pins pass through a two-stage synchronizer into the system clock domain, and their edges are detected there. The system clock must run at least eight times faster than the serial clock.

A 4-bit mode field sets how the select line is used. The value 0100 makes select gate the transfer: shifting happens only while select is low, and raising select aborts a partly shifted byte. The value 0101 ignores the select line, and the output is then always driven. A phase input picks when data changes on the line. In select-launched phase the falling edge of select puts the first bit on the output. That phase is legal only together with select control.

Software sees a parallel port. It writes the transmit byte, reads the received byte, and clears the flags with write-one-to-clear pulses. There are three flags: transfer done, write collision and receive overflow.

Top module: `spi_sel_slave`

## Requirements
- R1: The configuration is valid only for `cfg_mode` 4'b0100, or for `cfg_mode` 4'b0101 with `cfg_sel_launch` low. In any other configuration, including 0101 with `cfg_sel_launch` high, `sdo_oe` stays low and serial clock edges complete no byte.
- R2: Data moves most significant bit first in both directions. On completion, the eight sampled `sdi` bits appear on `rx_data`, with the first bit in bit 7. The transmit byte appears on `sdo`, bit 7 first.
- R3: `xfer_done` rises after the eighth sampling edge of a frame. It stays high until a cycle in which `flag_clr[0]` is high.
- R4: In mode 0100, `sdo_oe` follows `ss_n` directly with no clock delay. It is high while `ss_n` is low and low while `ss_n` is high, even in the middle of a byte.
- R5: In mode 0100, a rising `ss_n` partway through a byte discards the partial byte and raises no `xfer_done`. The next frame counts eight fresh bits.
- R6: With `cfg_sel_launch` high (sample on rising `sck`, change on falling `sck`), the falling edge of `ss_n` drives bit 7 of the transmit byte on `sdo` before any `sck` edge. In this phase each byte needs its own falling edge of `ss_n`.
- R7: A `wr_en` pulse during a frame sets `wr_collision` (flag bit 1, cleared by `flag_clr[1]`). It leaves the transmit buffer unchanged, so the next frame still sends the old byte.
- R8: If a byte completes while the previous one has not been read (`rd_en` marks it read), `rx_overflow` is set (flag bit 2, cleared by `flag_clr[2]`). In that case `rx_data` keeps the old byte.
- R9: In mode 0101 with `cfg_sel_launch` low, `sdo_oe` is high regardless of `ss_n`. Frames run without any select activity, and each frame starts at its first rising `sck` edge.
- R10: With `cfg_sel_launch` low, data changes on rising `sck` and is sampled on falling `sck`. A byte written while idle is loaded at the start of the next frame and sent in that frame.
- R11: In mode 0100, `sck` edges while `ss_n` is high shift nothing and advance no bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 4 | Mode field: 0100 select-gated, 0101 select ignored |
| cfg_sel_launch | input | 1 | 1: select fall launches first bit, sample on rising sck |
| sck | input | 1 | External serial clock, idle low |
| ss_n | input | 1 | Slave select, active low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo (pad tri-state control) |
| wr_en | input | 1 | Transmit buffer write strobe |
| wr_data | input | 8 | Transmit byte |
| rd_en | input | 1 | Marks the received byte as read |
| rx_data | output | 8 | Receive buffer |
| flag_clr | input | 3 | Write-one-to-clear: bit0 done, bit1 collision, bit2 overflow |
| xfer_done | output | 1 | Byte completed flag |
| wr_collision | output | 1 | Write-during-frame flag |
| rx_overflow | output | 1 | Unread-byte-overwritten flag |

## Verification
The checker watches several rules on every cycle:
- the output enable is low whenever the configuration is invalid or select is high in gated mode;
- no completion follows an invalid configuration;
- the done flag holds until cleared;
- a synchronized select rise empties the bit counter;
- a collision or an overflow never changes the buffer it protects.

Only the bench scenarios can show the rest. That covers the bit order of the bytes exchanged with a modelled master in both phases. It also covers the bit launched by the select fall, a clean restart after an aborted byte, the bytes actually sent after a collision, and clock pulses ignored while deselected.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;
  localparam logic [3:0] MODE_SEL_GATED  = 4'b0100;
  localparam logic [3:0] MODE_SEL_IGNORE = 4'b0101;
  localparam int FLG_DONE = 0;
  localparam int FLG_WCOL = 1;
  localparam int FLG_OVF  = 2;
  localparam int FLG_N    = 3;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], din[i]};
    end
    assign dout[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              ss_s,
  input  logic              sdi_s,
  input  logic              cfg_ok,
  input  logic              sel_ctl,
  input  logic              sel_launch,
  input  logic [DATA_W-1:0] tx_buf,
  output logic              sr_msb,
  output logic [DATA_W-1:0] rx_byte,
  output logic              complete,
  output logic              in_frame,
  output logic [$clog2(DATA_W)-1:0] bit_cnt
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              sck_q, ss_q, hold, frame;
  logic [DATA_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              hold_nx, frame_nx;
  logic [DATA_W-1:0] sr_nx;
  logic [CNT_W-1:0]  cnt_nx;
  logic lead, trail, ss_fall, ss_rise, active, samp, shft;

  always_comb begin
    lead    = sck_s & ~sck_q;
    trail   = ~sck_s & sck_q;
    ss_fall = ~ss_s & ss_q;
    ss_rise = ss_s & ~ss_q;
    active  = ~sel_ctl | ~ss_s;
    samp    = active & (sel_launch ? lead : trail);
    shft    = active & (sel_launch ? trail : lead);
    sr_nx    = sr;
    hold_nx  = hold;
    frame_nx = frame;
    cnt_nx   = cnt;
    complete = 1'b0;
    rx_byte  = {sr[DATA_W-2:0], sdi_s};
    if (!cfg_ok || (sel_ctl && ss_rise)) begin
      frame_nx = 1'b0;
      cnt_nx   = '0;
    end else if (sel_launch && ss_fall) begin
      sr_nx    = tx_buf;
      frame_nx = 1'b1;
      cnt_nx   = '0;
    end else begin
      if (shft) begin
        if (frame) begin
          sr_nx = {sr[DATA_W-2:0], hold};
        end else if (!sel_launch) begin
          sr_nx    = tx_buf;
          frame_nx = 1'b1;
          cnt_nx   = '0;
        end
      end
      if (samp && frame) begin
        hold_nx = sdi_s;
        if (cnt == LAST) begin
          complete = 1'b1;
          frame_nx = 1'b0;
          cnt_nx   = '0;
        end else begin
          cnt_nx = cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      ss_q  <= 1'b1;
      sr    <= '0;
      hold  <= 1'b0;
      frame <= 1'b0;
      cnt   <= '0;
    end else begin
      sck_q <= sck_s;
      ss_q  <= ss_s;
      sr    <= sr_nx;
      hold  <= hold_nx;
      frame <= frame_nx;
      cnt   <= cnt_nx;
    end
  end

  assign sr_msb   = sr[DATA_W-1];
  assign in_frame = frame;
  assign bit_cnt  = cnt;
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_sel_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [FLG_N-1:0]  flag_clr,
  input  logic              complete,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              busy,
  output logic [DATA_W-1:0] tx_buf,
  output logic [DATA_W-1:0] rx_data,
  output logic [FLG_N-1:0]  flags
);
  logic [DATA_W-1:0] tx_q, rx_q, tx_nx, rx_nx;
  logic [FLG_N-1:0]  flg_q, flg_nx;
  logic              full_q, full_nx, full_eff;

  always_comb begin
    tx_nx    = tx_q;
    rx_nx    = rx_q;
    flg_nx   = flg_q & ~flag_clr;
    full_eff = full_q & ~rd_en;
    full_nx  = full_eff;
    if (wr_en) begin
      if (busy) flg_nx[FLG_WCOL] = 1'b1;
      else      tx_nx = wr_data;
    end
    if (complete) begin
      flg_nx[FLG_DONE] = 1'b1;
      if (full_eff) begin
        flg_nx[FLG_OVF] = 1'b1;
      end else begin
        rx_nx   = rx_byte;
        full_nx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      flg_q  <= '0;
      full_q <= 1'b0;
    end else begin
      tx_q   <= tx_nx;
      rx_q   <= rx_nx;
      flg_q  <= flg_nx;
      full_q <= full_nx;
    end
  end

  assign tx_buf  = tx_q;
  assign rx_data = rx_q;
  assign flags   = flg_q;
endmodule

// File: rtl/spi_sel_slave.sv
module spi_sel_slave
  import spi_sel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cfg_mode,
  input  logic              cfg_sel_launch,
  input  logic              sck,
  input  logic              ss_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rx_data,
  input  logic [FLG_N-1:0]  flag_clr,
  output logic              xfer_done,
  output logic              wr_collision,
  output logic              rx_overflow
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [1:0]        rst_pipe;
  logic              rst_n_s;
  logic [2:0]        pins_s;
  logic              sck_s, ss_s, sdi_s;
  logic              sel_ctl, cfg_ok;
  logic              complete, in_frame, sr_msb;
  logic [DATA_W-1:0] rx_byte, tx_buf;
  logic [CNT_W-1:0]  bit_cnt;
  logic [FLG_N-1:0]  flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .din({sdi, ss_n, sck}), .dout(pins_s)
  );
  assign sck_s = pins_s[0];
  assign ss_s  = pins_s[1];
  assign sdi_s = pins_s[2];

  assign sel_ctl = (cfg_mode == MODE_SEL_GATED);
  assign cfg_ok  = sel_ctl | ((cfg_mode == MODE_SEL_IGNORE) & ~cfg_sel_launch);

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n_s), .sck_s(sck_s), .ss_s(ss_s), .sdi_s(sdi_s),
    .cfg_ok(cfg_ok), .sel_ctl(sel_ctl), .sel_launch(cfg_sel_launch),
    .tx_buf(tx_buf), .sr_msb(sr_msb), .rx_byte(rx_byte),
    .complete(complete), .in_frame(in_frame), .bit_cnt(bit_cnt)
  );

  spi_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .flag_clr(flag_clr), .complete(complete),
    .rx_byte(rx_byte), .busy(in_frame), .tx_buf(tx_buf),
    .rx_data(rx_data), .flags(flags)
  );

  assign sdo          = sr_msb;
  assign sdo_oe       = cfg_ok & (~sel_ctl | ~ss_n);
  assign xfer_done    = flags[FLG_DONE];
  assign wr_collision = flags[FLG_WCOL];
  assign rx_overflow  = flags[FLG_OVF];
endmodule

// File: rtl/spi_sel_slave_chk.sv
module spi_sel_slave_chk
  import spi_sel_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic [3:0]        cfg_mode,
  input logic              cfg_sel_launch,
  input logic              ss_n,
  input logic              ss_s,
  input logic              sdo_oe,
  input logic              xfer_done,
  input logic              wr_collision,
  input logic              rx_overflow,
  input logic [FLG_N-1:0]  flag_clr,
  input logic [DATA_W-1:0] rx_data,
  input logic [DATA_W-1:0] tx_buf,
  input logic              in_frame,
  input logic [$clog2(DATA_W)-1:0] bit_cnt
);
  logic cfg_bad;
  assign cfg_bad = !((cfg_mode == MODE_SEL_GATED) ||
                     ((cfg_mode == MODE_SEL_IGNORE) && !cfg_sel_launch));

  // R1: invalid configuration keeps the pad released
  a_r1_invalid_no_drive: assert property (@(posedge clk) disable iff (!rst_n_s)
    cfg_bad |-> !sdo_oe);
  // R1: invalid configuration completes no byte
  a_r1_invalid_no_done: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_bad && !xfer_done) |=> !xfer_done);
  // R4: deselected in gated mode means output released
  a_r4_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_mode == MODE_SEL_GATED && ss_n) |-> !sdo_oe);
  // R3: done is sticky until its clear bit
  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n_s)
    (xfer_done && !flag_clr[FLG_DONE]) |=> xfer_done);
  // R5: a synchronized select rise empties the bit counter
  a_r5_abort_resets_count: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_mode == MODE_SEL_GATED && $rose(ss_s)) |=> (!in_frame && bit_cnt == '0));
  // R7: a collision leaves the transmit buffer alone
  a_r7_wcol_keeps_tx: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(wr_collision) |-> $stable(tx_buf));
  // R8: an overflow leaves the receive buffer alone
  a_r8_ovf_keeps_rx: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rx_overflow) |-> $stable(rx_data));
endmodule

bind spi_sel_slave spi_sel_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .cfg_mode(cfg_mode),
  .cfg_sel_launch(cfg_sel_launch), .ss_n(ss_n), .ss_s(ss_s),
  .sdo_oe(sdo_oe), .xfer_done(xfer_done), .wr_collision(wr_collision),
  .rx_overflow(rx_overflow), .flag_clr(flag_clr), .rx_data(rx_data),
  .tx_buf(tx_buf), .in_frame(in_frame), .bit_cnt(bit_cnt)
);

// File: tb/sim_spi_sel_slave.sv
`timescale 1ns/1ps
module sim_spi_sel_slave;
  localparam int HALF = 8;

  logic clk, rst_n;
  logic [3:0] cfg_mode;
  logic cfg_sel_launch, sck, ss_n, sdi, sdo, sdo_oe;
  logic wr_en, rd_en;
  logic [7:0] wr_data, rx_data;
  logic [2:0] flag_clr;
  logic xfer_done, wr_collision, rx_overflow;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  logic done_prev = 1'b0;
  bit   mon_on = 1'b0;

  spi_sel_slave u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_sel_launch(cfg_sel_launch),
    .sck(sck), .ss_n(ss_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rx_data(rx_data),
    .flag_clr(flag_clr), .xfer_done(xfer_done), .wr_collision(wr_collision),
    .rx_overflow(rx_overflow)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // monitor: pop an expected receive byte at each done rise
  always @(negedge clk) begin
    if (mon_on && xfer_done && !done_prev) begin
      if (exp_q.size() == 0) check("R2 unexpected done", 32'h1, 32'h0);
      else check("R2 rx byte", {24'h0, rx_data}, {24'h0, exp_q.pop_front()});
    end
    done_prev = xfer_done;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic half_bit();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic write_tx(input logic [7:0] v);
    @(negedge clk); wr_data = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic service(input logic do_rd, input logic [2:0] clr);
    @(negedge clk); rd_en = do_rd; flag_clr = clr;
    @(negedge clk); rd_en = 1'b0; flag_clr = 3'b000;
  endtask

  task automatic xfer(input logic [7:0] mosi, input bit launch, input bit use_ss,
                      input int nbits, input bit do_wr, input logic [7:0] wval,
                      output logic [7:0] miso);
    miso = '0;
    @(negedge clk);
    if (use_ss) ss_n = 1'b0;
    if (launch) sdi = mosi[7];
    half_bit();
    for (int i = 0; i < nbits; i++) begin
      if (launch) begin
        miso = {miso[6:0], sdo};
        sck = 1'b1; half_bit();
        sck = 1'b0; if (i < 7) sdi = mosi[6-i]; half_bit();
      end else begin
        sck = 1'b1; sdi = mosi[7-i]; half_bit();
        miso = {miso[6:0], sdo};
        sck = 1'b0; half_bit();
      end
      if (do_wr && i == 3) begin
        wr_data = wval; wr_en = 1'b1; @(negedge clk); wr_en = 1'b0;
      end
    end
    if (use_ss) ss_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_sck(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sck = 1'b1; half_bit(); sck = 1'b0; half_bit();
    end
  endtask

  logic [7:0] got;

  initial begin
    rst_n = 1'b0; cfg_mode = 4'b0100; cfg_sel_launch = 1'b0;
    sck = 1'b0; ss_n = 1'b1; sdi = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0; flag_clr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // reset state
    check("R4 reset oe", {31'h0, sdo_oe}, 32'h0);
    check("R3 reset done", {31'h0, xfer_done}, 32'h0);
    check("R8 reset rx", {24'h0, rx_data}, 32'h0);

    // R10 / R2: gated mode, change on rising, sample on falling
    write_tx(8'h3C);
    exp_q.push_back(8'hA5);
    xfer(8'hA5, 1'b0, 1'b1, 8, 1'b0, 8'h00, got);
    check("R10 tx byte loaded at frame start", {24'h0, got}, 32'h3C);
    check("R3 done raised", {31'h0, xfer_done}, 32'h1);
    repeat (20) @(negedge clk);
    check("R3 done held", {31'h0, xfer_done}, 32'h1);
    service(1'b1, 3'b001);
    check("R3 done cleared", {31'h0, xfer_done}, 32'h0);

    // R4: enable follows select immediately
    @(negedge clk); ss_n = 1'b0; #1;
    check("R4 oe while selected", {31'h0, sdo_oe}, 32'h1);
    @(negedge clk); ss_n = 1'b1; #1;
    check("R4 oe released at once", {31'h0, sdo_oe}, 32'h0);

    // R5: abort after three bits, then a clean byte
    xfer(8'hFF, 1'b0, 1'b1, 3, 1'b0, 8'h00, got);
    check("R5 no done on abort", {31'h0, xfer_done}, 32'h0);
    check("R5 oe released after abort", {31'h0, sdo_oe}, 32'h0);
    exp_q.push_back(8'h81);
    write_tx(8'h96);
    xfer(8'h81, 1'b0, 1'b1, 8, 1'b0, 8'h00, got);
    check("R5 restart tx", {24'h0, got}, 32'h96);
    check("R5 restart done", {31'h0, xfer_done}, 32'h1);
    service(1'b1, 3'b111);

    // R11: clock pulses while deselected
    pulse_sck(8);
    check("R11 no done while deselected", {31'h0, xfer_done}, 32'h0);
    check("R11 rx untouched", {24'h0, rx_data}, 32'h81);
    exp_q.push_back(8'h5E);
    xfer(8'h5E, 1'b0, 1'b1, 8, 1'b0, 8'h00, got);
    check("R11 following byte intact", {24'h0, got}, 32'h96);
    service(1'b1, 3'b111);

    // R6: select-launched phase
    cfg_sel_launch = 1'b1;
    write_tx(8'h80);
    @(negedge clk); ss_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R6 first bit before sck", {31'h0, sdo}, 32'h1);
    @(negedge clk); ss_n = 1'b1;
    repeat (6) @(negedge clk);
    write_tx(8'hC3);
    exp_q.push_back(8'h69);
    xfer(8'h69, 1'b1, 1'b1, 8, 1'b0, 8'h00, got);
    check("R6 launched phase tx", {24'h0, got}, 32'hC3);
    check("R2 launched phase rx", {24'h0, rx_data}, 32'h69);
    service(1'b1, 3'b111);
    cfg_sel_launch = 1'b0;

    // R7: write collision
    write_tx(8'h5A);
    exp_q.push_back(8'h12);
    xfer(8'h12, 1'b0, 1'b1, 8, 1'b1, 8'hEE, got);
    check("R7 collision flag", {31'h0, wr_collision}, 32'h1);
    check("R7 frame kept old tx", {24'h0, got}, 32'h5A);
    service(1'b1, 3'b111);
    exp_q.push_back(8'h34);
    xfer(8'h34, 1'b0, 1'b1, 8, 1'b0, 8'h00, got);
    check("R7 ignored write not sent", {24'h0, got}, 32'h5A);
    service(1'b1, 3'b111);

    // R8: overflow keeps the unread byte
    exp_q.push_back(8'h11);
    xfer(8'h11, 1'b0, 1'b1, 8, 1'b0, 8'h00, got);
    service(1'b0, 3'b001);
    exp_q.push_back(8'h11);
    xfer(8'h22, 1'b0, 1'b1, 8, 1'b0, 8'h00, got);
    check("R8 overflow flag", {31'h0, rx_overflow}, 32'h1);
    check("R8 old byte kept", {24'h0, rx_data}, 32'h11);
    service(1'b1, 3'b111);

    // R9: select ignored
    cfg_mode = 4'b0101;
    repeat (2) @(negedge clk);
    check("R9 oe with ss high", {31'h0, sdo_oe}, 32'h1);
    write_tx(8'hB7);
    exp_q.push_back(8'h4D);
    xfer(8'h4D, 1'b0, 1'b0, 8, 1'b0, 8'h00, got);
    check("R9 tx without select", {24'h0, got}, 32'hB7);
    check("R9 done without select", {31'h0, xfer_done}, 32'h1);
    service(1'b1, 3'b111);

    // R1: invalid configurations
    cfg_sel_launch = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 ignore+launch oe", {31'h0, sdo_oe}, 32'h0);
    @(negedge clk); ss_n = 1'b0;
    pulse_sck(8);
    @(negedge clk); ss_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 ignore+launch no done", {31'h0, xfer_done}, 32'h0);
    cfg_sel_launch = 1'b0; cfg_mode = 4'b0000;
    @(negedge clk); ss_n = 1'b0; #1;
    check("R1 mode 0000 oe", {31'h0, sdo_oe}, 32'h0);
    pulse_sck(8);
    @(negedge clk); ss_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 mode 0000 no done", {31'h0, xfer_done}, 32'h0);

    check("R2 scoreboard drained", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule